// File: doc/BRIEF.md
# Misaligned load data formatter

This block turns the raw 32-bit word returned by a memory read port into the value a small 32-bit CPU writes back to its register file. Each request carries the bus word, the low two address bits, an access size (byte, halfword or word), a signed flag and a PC-relative flag. A misaligned word or halfword load does not raise a fault. The block rotates the data so that the addressed byte ends up in the low lane, and it applies zero or sign extension as the access size and signedness require. The bus word is little-endian: byte lane n occupies bits 8n+7:8n.

Requests and results move through one register stage with valid/ready handshakes on both sides. A request is taken on a rising edge when `in_valid` and `in_ready` are both high. The result is offered on `out_valid`/`out_data` and stays unchanged until the consumer raises `out_ready`. `in_ready` is high whenever the stage is empty or its result leaves in the same cycle. A full stage that is stalled therefore pushes back on the producer at once, and a stream with no stalls runs at one request per cycle. The reset input is active-low and synchronous.

Top module: `ld_align_fmt`

## Requirements
- R1: A word load (size 10) returns the bus word rotated right by 8 times the low address bits, so the addressed byte lands in bits 7:0.
- R2: An unsigned halfword load (size 01) takes bits 15:0 of the bus word when address bit 1 is 0 and bits 31:16 when it is 1, zero-extends that halfword, and rotates the 32-bit value right by 8 when address bit 0 is 1.
- R3: A signed halfword load at an even address returns the selected halfword sign-extended from its bit 15.
- R4: A signed halfword load at an odd address returns the addressed byte (the upper byte of the selected halfword) sign-extended from its bit 7, which is the same value a signed byte load of that address returns.
- R5: A byte load (size 00) takes byte lane n, where n is the low address bits, and zero-extends it when unsigned or sign-extends it from bit 7 when signed.
- R6: Size encoding 11 is reserved and returns zero.
- R7: The signed flag has no effect on a word load.
- R8: When the PC-relative flag is set, the low address bits are treated as 00, because a PC-relative address is a PC with bits 1:0 cleared plus a word-multiple offset.
- R9: A request is accepted exactly when `in_valid` and `in_ready` are both high, with `in_ready` high when the stage is empty or `out_ready` is high. Results leave in acceptance order, none is lost or duplicated, and while `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R10: During reset `out_valid` is 0, `out_data` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Stage can take the request this cycle |
| in_data | input | 32 | Raw word from the memory read port |
| in_addr_lo | input | 2 | Low bits of the load address |
| in_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| in_signed | input | 1 | Sign-extend byte and halfword results |
| in_pcrel | input | 1 | PC-relative load; low address bits forced to 00 |
| out_valid | output | 1 | Formatted result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Value for the register-file write port |

## Verification
Two functions can fall in the same cycle: the consumer drains the held result while the producer hands in a new request, so the stage is emptied and refilled on one edge. The bench provokes this by driving `out_ready` at random with about one stall in four, while requests arrive back to back with only occasional gaps. Each result is compared in order against a queue of values the bench computes from the accepted requests. Any lost, duplicated or reordered result, and any result that changes during a stall, shows up as a mismatch.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  // access size as carried on the request
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } ld_size_e;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned HALF_W = 16;

endpackage

// File: rtl/ldfmt_lane_rot.sv
// Rotates a bus word right by a whole number of byte lanes.
module ldfmt_lane_rot #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / ldfmt_pkg::LANE_W,
  localparam int unsigned SH_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned LW = ldfmt_pkg::LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SH_W-1:0] src;
    always_comb begin
      src = SH_W'(g) + sh;  // wraps modulo LANES (power of two)
      dout[g*LW +: LW] = din[src*LW +: LW];
    end
  end

endmodule

// File: rtl/ldfmt_extract.sv
// Combinational byte/halfword/word selection, rotation and extension.
module ldfmt_extract #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / ldfmt_pkg::LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]     din,
  input  logic [OFS_W-1:0]      ofs,
  input  ldfmt_pkg::ld_size_e   size,
  input  logic                  sgn,
  output logic [DATA_W-1:0]     res
);
  import ldfmt_pkg::*;

  localparam int unsigned HW_IDX_W = (OFS_W > 1) ? OFS_W - 1 : 1;

  logic [DATA_W-1:0] word_rot;
  logic [DATA_W-1:0] half_zext;
  logic [DATA_W-1:0] half_rot;
  logic [OFS_W-1:0]  half_sh;
  logic [HW_IDX_W-1:0] hw_idx;
  logic [HALF_W-1:0] hw;
  logic [LANE_W-1:0] bsel;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] byte_res;

  // full-word rotation by the byte offset
  ldfmt_lane_rot #(.DATA_W(DATA_W)) u_word_rot (
    .din  (din),
    .sh   (ofs),
    .dout (word_rot)
  );

  // halfword at the halfword-aligned position
  always_comb begin
    hw_idx    = HW_IDX_W'(ofs >> 1);
    hw        = din[hw_idx*HALF_W +: HALF_W];
    half_zext = DATA_W'(hw);
    half_sh   = OFS_W'(ofs[0]);
  end

  // odd halfword address: rotate the zero-extended halfword one lane
  ldfmt_lane_rot #(.DATA_W(DATA_W)) u_half_rot (
    .din  (half_zext),
    .sh   (half_sh),
    .dout (half_rot)
  );

  always_comb begin
    if (!sgn) begin
      half_res = half_rot;
    end else if (!ofs[0]) begin
      half_res = {{(DATA_W-HALF_W){hw[HALF_W-1]}}, hw};
    end else begin
      // addressed byte is the upper byte of the selected halfword
      half_res = {{(DATA_W-LANE_W){hw[HALF_W-1]}}, hw[HALF_W-1 -: LANE_W]};
    end
  end

  always_comb begin
    bsel     = din[ofs*LANE_W +: LANE_W];
    byte_res = sgn ? {{(DATA_W-LANE_W){bsel[LANE_W-1]}}, bsel}
                   : DATA_W'(bsel);
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: res = byte_res;
      SZ_HALF: res = half_res;
      SZ_WORD: res = word_rot;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/ldfmt_stage.sv
// One-entry valid/ready register stage.
module ldfmt_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              v_q;
  logic [DATA_W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) d_q <= in_data;
    end
  end

  // R9: a stalled result neither disappears nor changes
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: an accepted request is offered in the next cycle
  p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9: with nothing accepted and the result taken, the stage empties
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/ld_align_fmt.sv
// Load data formatter: rotation and extension of bus read data.
module ld_align_fmt #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / ldfmt_pkg::LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [OFS_W-1:0]  in_addr_lo,
  input  logic [1:0]        in_size,
  input  logic              in_signed,
  input  logic              in_pcrel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import ldfmt_pkg::*;

  logic [OFS_W-1:0]  eff_ofs;
  logic [DATA_W-1:0] fmt_data;
  ld_size_e          size_e;

  // PC-relative addresses are word aligned
  assign eff_ofs = in_pcrel ? '0 : in_addr_lo;
  assign size_e  = ld_size_e'(in_size);

  ldfmt_extract #(.DATA_W(DATA_W)) u_extract (
    .din  (in_data),
    .ofs  (eff_ofs),
    .size (size_e),
    .sgn  (in_signed),
    .res  (fmt_data)
  );

  ldfmt_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (fmt_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  logic fire;
  assign fire = in_valid && in_ready;

  // R6: reserved size gives zero
  p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b11) |=> (out_data == '0));

  // R1: word load puts the addressed byte in the low lane
  p_word_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b10) |=>
      (out_data[7:0] == 8'($past(in_data >> (8 * (in_pcrel ? 0 : in_addr_lo))))));

  // R5: unsigned byte load clears everything above the byte
  p_ubyte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b00 && !in_signed) |=> (out_data[DATA_W-1:8] == '0));

  // R2: unsigned even halfword clears the upper half
  p_uhalf_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b01 && !in_signed && !eff_ofs[0]) |=>
      (out_data[DATA_W-1:16] == '0));

  // R3: signed even halfword replicates bit 15 upward
  p_shalf_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b01 && in_signed && !eff_ofs[0]) |=>
      (out_data[DATA_W-1:16] == {(DATA_W-16){out_data[15]}}));

  // R4: signed odd halfword replicates bit 7 upward
  p_shalf_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_size == 2'b01 && in_signed && eff_ofs[0]) |=>
      (out_data[DATA_W-1:8] == {(DATA_W-8){out_data[7]}}));

endmodule

// File: tb/test_ld_align_fmt.sv
module test_ld_align_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_addr_lo = '0;
  logic [1:0]  in_size = '0;
  logic        in_signed = 1'b0;
  logic        in_pcrel = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_vec = 0;
  int n_bad = 0;
  bit rnd_ready = 1'b0;
  bit done = 1'b0;
  bit stall_prev = 1'b0;
  logic [31:0] stall_data = '0;
  logic [37:0] q[$];  // {pcrel, sgn, size, ofs, data}

  always #4 clk = ~clk;  // 125 MHz

  ld_align_fmt i_ld_align_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_addr_lo(in_addr_lo), .in_size(in_size),
    .in_signed(in_signed), .in_pcrel(in_pcrel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] ref_fmt(logic [31:0] d, logic [1:0] o_in,
                                          logic [1:0] sz, logic sg, logic pc);
    logic [1:0]  o;
    logic [63:0] dd;
    logic [15:0] hw;
    logic [7:0]  b;
    o  = pc ? 2'b00 : o_in;
    dd = {d, d};
    hw = o[1] ? d[31:16] : d[15:0];
    b  = 8'(d >> (8 * o));
    case (sz)
      2'b00: return sg ? {{24{b[7]}}, b} : {24'h0, b};
      2'b01: begin
        if (!o[0]) return sg ? {{16{hw[15]}}, hw} : {16'h0, hw};
        return sg ? {{24{hw[15]}}, hw[15:8]} : {hw[7:0], 16'h0, hw[15:8]};
      end
      2'b10: return 32'(dd >> (8 * o));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] o, logic [1:0] sz, logic sg, logic pc);
    if (pc && o != 2'b00) return "R8";
    case (sz)
      2'b00: return "R5";
      2'b01: return !sg ? "R2" : ((o[0] && !pc) ? "R4" : "R3");
      2'b10: return sg ? "R7" : "R1";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] d, logic [1:0] o, logic [1:0] sz, logic sg, logic pc);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_addr_lo = o; in_size = sz;
    in_signed = sg; in_pcrel = pc;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure
  always @(negedge clk) begin
    out_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // monitor, samples 1 ns before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (stall_prev)
        chk(out_valid && out_data == stall_data, "R9", "stalled result held",
            out_data, stall_data);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected result", out_data, 32'h0);
        end else begin
          logic [37:0] e;
          logic [31:0] exp;
          e   = q.pop_front();
          exp = ref_fmt(e[31:0], e[33:32], e[35:34], e[36], e[37]);
          chk(out_data == exp, tag_of(e[33:32], e[35:34], e[36], e[37]),
              "formatted data", out_data, exp);
        end
      end
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (in_valid && in_ready)
        q.push_back({in_pcrel, in_signed, in_size, in_addr_lo, in_data});
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL R9 watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats[2];
    void'($urandom(32'd20240611));
    pats[0] = 32'hF1837264;
    pats[1] = 32'h1F38E7C6;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'h0);
    chk(out_data == 32'h0, "R10", "out_data in reset", out_data, 32'h0);
    chk(in_ready == 1'b1, "R10", "in_ready in reset", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // directed: every size, signedness and offset (R1..R7), no stalls
    for (int p = 0; p < 2; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int sg = 0; sg < 2; sg++)
          for (int o = 0; o < 4; o++)
            send(pats[p], 2'(o), 2'(sz), 1'(sg), 1'b0);
    // R8: PC-relative ignores the low address bits
    for (int sz = 0; sz < 3; sz++)
      for (int o = 1; o < 4; o++)
        send(pats[0], 2'(o), 2'(sz), 1'b1, 1'b1);
    idle();

    // random stream with back-pressure (R9 with everything else)
    rnd_ready = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 10) == 0) idle();
      send($urandom, 2'($urandom), 2'($urandom), 1'($urandom),
           (($urandom % 8) == 0));
    end
    idle();
    rnd_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9", "all results delivered", 32'(q.size()), 32'h0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule